// File: doc/BRIEF.md
# Flash write pulse sequencer

This block drives one program pulse into an on-chip flash array. A start strobe launches a fixed sequence on three control outputs. The watchdog enable rises first. The program-setup enable follows, then the program enable. They are released in the opposite order. Each step is separated by a timed wait.

Every wait is given as a clock-cycle count on its own input. The pulse length is chosen from three count inputs (short, medium, long) by a two-bit select. All counts and the select are captured when the start strobe is accepted, so later changes on those inputs do not touch a sequence already running. A single-cycle done strobe marks the end of the sequence.

Choosing the pulse width, moving the data and verifying the result are the job of the surrounding controller.

Top module: `flash_pulse_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `wdt_en`, `prog_setup`, `prog_en` and `done` are all low.
- R2: A `start` sampled high while the block is idle raises `wdt_en` on the next clock edge, with `prog_setup` still low. `prog_setup` rises exactly one cycle after `wdt_en`.
- R3: `prog_setup` stays high with `prog_en` low for `t_setup` cycles before `prog_en` rises. A count of 0 acts as 1, and this holds for every wait.
- R4: `prog_en` stays high for the selected pulse count. `width_sel` 2'b00 selects `t_short`, 2'b01 selects `t_medium`, and 2'b10 or 2'b11 selects `t_long`.
- R5: After `prog_en` falls, `prog_setup` stays high for `t_pulse_rec` cycles, then falls.
- R6: After `prog_setup` falls, `wdt_en` stays high for `t_setup_rec` cycles. It then falls in the same cycle that `done` goes high, and `done` stays high for exactly one cycle.
- R7: `start` is ignored at any time other than idle, including the done cycle. A strobe of this kind neither restarts nor extends the sequence, and it starts no further sequence afterwards.
- R8: All wait counts and `width_sel` are captured when `start` is accepted. Changing them while a sequence runs has no effect on it.
- R9: `prog_en` is never high while `prog_setup` is low, and `prog_setup` is never high while `wdt_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one pulse sequence when idle |
| width_sel | input | 2 | Pulse width select: 0 short, 1 medium, 2/3 long |
| t_setup | input | CW | Setup wait, in cycles |
| t_short | input | CW | Short pulse length, in cycles |
| t_medium | input | CW | Medium pulse length, in cycles |
| t_long | input | CW | Long pulse length, in cycles |
| t_pulse_rec | input | CW | Wait after program enable falls, in cycles |
| t_setup_rec | input | CW | Wait after program-setup falls, in cycles |
| wdt_en | output | 1 | Watchdog enable, high for the whole sequence |
| prog_setup | output | 1 | Program-setup enable |
| prog_en | output | 1 | Program enable (the pulse) |
| done | output | 1 | One-cycle end-of-sequence strobe |

## Verification
The hardest case to reach is a sequence disturbed while it runs. In that case a new start strobe arrives together with a different width select and different wait counts. The stimulus holds `start` high across the accept cycle and the next one. In mid-pulse it changes every count and the select and pulses `start` again. The phase lengths measured at the ports must still match the values captured at launch. The bench then watches an idle stretch to confirm that no second sequence appears. Zero counts, which must behave as one cycle, and the two encodings that both select the long pulse are run as separate sequences.

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    width_sel,
  input  logic [CW-1:0] t_setup,
  input  logic [CW-1:0] t_short,
  input  logic [CW-1:0] t_medium,
  input  logic [CW-1:0] t_long,
  input  logic [CW-1:0] t_pulse_rec,
  input  logic [CW-1:0] t_setup_rec,
  output logic          wdt_en,
  output logic          prog_setup,
  output logic          prog_en,
  output logic          done
);

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_SETUP, S_PULSE, S_PREC, S_SREC, S_FIN
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] r_set, r_pls, r_prec, r_srec;
  logic [CW-1:0] pick;
  logic          last;

  assign pick = (width_sel == 2'd0) ? t_short :
                (width_sel == 2'd1) ? t_medium : t_long;
  assign last = (cnt <= {{(CW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      r_set  <= '0;
      r_pls  <= '0;
      r_prec <= '0;
      r_srec <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          r_set  <= t_setup;
          r_pls  <= pick;
          r_prec <= t_pulse_rec;
          r_srec <= t_setup_rec;
          st     <= S_ARM;
        end
        S_ARM: begin
          cnt <= r_set;
          st  <= S_SETUP;
        end
        S_SETUP: if (last) begin
          cnt <= r_pls;
          st  <= S_PULSE;
        end else cnt <= cnt - 1'b1;
        S_PULSE: if (last) begin
          cnt <= r_prec;
          st  <= S_PREC;
        end else cnt <= cnt - 1'b1;
        S_PREC: if (last) begin
          cnt <= r_srec;
          st  <= S_SREC;
        end else cnt <= cnt - 1'b1;
        S_SREC: if (last) st <= S_FIN;
                else cnt <= cnt - 1'b1;
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wdt_en     = (st != S_IDLE) && (st != S_FIN);
  assign prog_setup = (st == S_SETUP) || (st == S_PULSE) || (st == S_PREC);
  assign prog_en    = (st == S_PULSE);
  assign done       = (st == S_FIN);

  AST_SETUP_COVERS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> prog_setup); // R9
  AST_WDT_COVERS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    prog_setup |-> wdt_en); // R9
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wdt_en && !done) |=> (wdt_en && !prog_setup)); // R2
  AST_SETUP_AFTER_WDT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_setup) |-> $past(wdt_en)); // R2
  AST_PROG_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_en) |-> $past(prog_setup)); // R3
  AST_WDT_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_en) |-> done); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !wdt_en); // R7

endmodule

// File: tb/tb_flash_pulse_seq.sv
module tb_flash_pulse_seq;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    width_sel = '0;
  logic [CW-1:0] t_setup = '0, t_short = '0, t_medium = '0, t_long = '0;
  logic [CW-1:0] t_pulse_rec = '0, t_setup_rec = '0;
  logic          wdt_en, prog_setup, prog_en, done;

  flash_pulse_seq #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel),
    .t_setup(t_setup), .t_short(t_short), .t_medium(t_medium), .t_long(t_long),
    .t_pulse_rec(t_pulse_rec), .t_setup_rec(t_setup_rec),
    .wdt_en(wdt_en), .prog_setup(prog_setup), .prog_en(prog_en), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int su; int pl; int pr; int sr; } exp_t;
  exp_t exp_q[$];

  int checks = 0, fails = 0, ops_seen = 0, cycles = 0;

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int m1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // monitor
  bit active = 0, seen_set = 0, seen_prog = 0, bad_inv = 0, bad_done = 0, prev_done = 0;
  int c_arm, c_set, c_pul, c_rec, c_srec;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if ((prog_en && !prog_setup) || (prog_setup && !wdt_en)) bad_inv = 1;
      if (done && prev_done) bad_done = 1;
      if (!active && wdt_en) begin
        active = 1; seen_set = 0; seen_prog = 0;
        c_arm = 0; c_set = 0; c_pul = 0; c_rec = 0; c_srec = 0;
        bad_inv = 0; bad_done = 0;
      end
      if (active) begin
        if (wdt_en) begin
          if (!prog_setup && !seen_set) c_arm++;
          else if (prog_setup && !prog_en && !seen_prog) begin c_set++; seen_set = 1; end
          else if (prog_en) begin c_pul++; seen_prog = 1; end
          else if (prog_setup && seen_prog) c_rec++;
          else if (!prog_setup && seen_set) c_srec++;
          if (done) bad_done = 1;
        end else begin
          exp_t e;
          active = 0;
          if (exp_q.size() == 0) begin
            check("R7", "unexpected sequence", 1, 0);
          end else begin
            e = exp_q.pop_front();
            check("R2", "wdt-only lead cycles", c_arm, 1);
            check("R3", "setup wait", c_set, m1(e.su));
            check("R4", "pulse length", c_pul, m1(e.pl));
            check("R5", "pulse recovery", c_rec, m1(e.pr));
            check("R6", "setup recovery", c_srec, m1(e.sr));
            check("R6", "done at wdt drop", int'(done), 1);
            check("R9", "enable nesting violated", int'(bad_inv), 0);
          end
          ops_seen++;
        end
      end
      prev_done = done;
    end
  end

  // driver
  task automatic run_op(int su, int sh, int md, int lg, int sel, int pr, int sr, bit disturb);
    exp_t e;
    int target;
    @(negedge clk);
    t_setup = su[CW-1:0]; t_short = sh[CW-1:0]; t_medium = md[CW-1:0];
    t_long = lg[CW-1:0]; t_pulse_rec = pr[CW-1:0]; t_setup_rec = sr[CW-1:0];
    width_sel = sel[1:0];
    e.su = su; e.pl = (sel == 0) ? sh : (sel == 1) ? md : lg; e.pr = pr; e.sr = sr;
    exp_q.push_back(e);
    target = ops_seen + 1;
    start = 1'b1;
    @(negedge clk);
    if (!disturb) start = 1'b0;
    else begin
      @(negedge clk); start = 1'b0;  // R7: held through the arm cycle
      repeat (su + 2) @(negedge clk);
      // R8: change every capture input mid-sequence and pulse start again
      t_setup = 16'd1; t_short = 16'd1; t_medium = 16'd1; t_long = 16'd30;
      t_pulse_rec = 16'd7; t_setup_rec = 16'd7; width_sel = 2'd2;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (ops_seen < target) begin
      @(negedge clk);
      if (disturb && done) start = 1'b1;   // R7: start in the done cycle
      else if (disturb) start = 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset outputs", {28'd0, wdt_en, prog_setup, prog_en, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset", {28'd0, wdt_en, prog_setup, prog_en, done}, 0);

    run_op(3, 2, 5, 9, 0, 2, 4, 0);   // R4 short
    run_op(2, 2, 5, 9, 1, 3, 1, 0);   // R4 medium
    run_op(1, 2, 5, 9, 2, 1, 2, 0);   // R4 long, sel 2
    run_op(4, 2, 5, 11, 3, 2, 3, 0);  // R4 long, sel 3
    run_op(0, 0, 0, 0, 0, 0, 0, 0);   // R3 zero counts act as one
    run_op(20, 3, 8, 25, 2, 15, 12, 0);
    run_op(2, 4, 12, 3, 1, 2, 2, 1);  // R7 R8 disturbed sequence
    run_op(1, 6, 1, 1, 0, 1, 1, 0);   // back-to-back after disturbance

    begin
      int wd_hi = 0;
      repeat (40) begin @(negedge clk); if (wdt_en) wd_hi++; end
      check("R7", "activity after ignored starts", wd_hi, 0);
      check("R7", "leftover expected sequences", exp_q.size(), 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule